// File: doc/BRIEF.md
# Host-Side Status Flag Word

This block forms a single read-only 16-bit status word for an external host processor. The host reads it over the host port. The word gathers three kinds of indication. First, latched handshake flags for the two mailbox directions. Second, latched "message written" flags, one for each of two serial interface engines, set by the embedded CPU. Third, interrupt levels from the two USB engines, together with two OTG pin levels. The embedded CPU has no path to this word.

Different agents clear the latched flags. Each engine message flag clears when the host reads this word. The incoming-mailbox flag clears only when the embedded CPU reads the mailbox. The outgoing-mailbox flag clears when the host takes the outgoing message. A read of this word only copies flop outputs into a register, so it never starts a memory cycle and the host may poll it continuously.

When a set and a clear reach the same flag in the same cycle, the set wins, so no event is lost. The two OTG levels pass through a synchronizer and are reported live, not latched.

Top module: `hps_status_word`

## Requirements
- R1: Bit layout of `stat_rdata`, by bit position:
  - 15: VBUS above threshold
  - 14: ID pin
  - 12: engine-2 SOF/EOP
  - 10: engine-1 SOF/EOP
  - 9: engine-2 USB reset
  - 8: incoming-mailbox flag
  - 7: engine-2 resume
  - 6: engine-1 resume
  - 5: engine-2 message flag
  - 4: engine-1 message flag
  - 3: engine-2 done
  - 2: engine-1 done
  - 1: engine-1 USB reset
  - 0: outgoing-mailbox flag
  
  Bits 13 and 11 always read 0. In every two-bit input vector, index 0 is engine 1 and index 1 is engine 2.
- R2: `stat_rdata` is registered. It takes the new status word at the clock edge where `host_rd` is sampled high, and it holds its value at every other edge.
- R3: While `rst_n` is low at a clock edge, `stat_rdata` and every latched flag go to 0.
- R4: A pulse on `cpu_msg_wr[n]` sets the matching engine message flag. A host read (`host_rd`) clears it.
- R5: A pulse on `mbx_in_put` sets the incoming-mailbox flag. Only `cpu_mbx_rd` clears it. A host read of this word leaves it unchanged.
- R6: A pulse on `cpu_mbx_put` sets the outgoing-mailbox flag. `host_mbx_take` clears it. A host read of this word leaves it unchanged.
- R7: If a set and a clear reach the same latched flag in the same cycle, the flag is 1 afterwards.
- R8: Each done bit depends on `eng_dev_mode[n]`. When it is 0 (host mode), the bit shows `eng_pkt_done[n]`. When it is 1 (device mode), the bit shows `eng_ep_irq[n]`.
- R9: The SOF/EOP, USB reset and resume bits show the engine interrupt input levels sampled at the read edge.
- R10: VBUS and ID pass through a two-stage synchronizer and are reported as live levels. A read sampled at the edge right after an input change still shows the old level. A read taken three edges after the change shows the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe for the status word |
| vbus_hi_async | input | 1 | Asynchronous VBUS-above-threshold level |
| id_async | input | 1 | Asynchronous OTG ID pin level |
| mbx_in_put | input | 1 | Pulse: message placed in incoming mailbox |
| cpu_mbx_rd | input | 1 | Pulse: embedded CPU read the incoming mailbox |
| cpu_mbx_put | input | 1 | Pulse: embedded CPU placed an outgoing message |
| host_mbx_take | input | 1 | Pulse: host took the outgoing message |
| cpu_msg_wr | input | 2 | Pulses: embedded CPU wrote engine message register |
| eng_sof_irq | input | 2 | SOF/EOP interrupt levels per engine |
| eng_rst_irq | input | 2 | USB reset interrupt levels per engine |
| eng_resume_irq | input | 2 | Resume interrupt levels per engine |
| eng_pkt_done | input | 2 | Host-mode packet-done levels per engine |
| eng_ep_irq | input | 2 | Device-mode any-endpoint interrupt levels per engine |
| eng_dev_mode | input | 2 | Per engine: 1 = device mode, 0 = host mode |
| stat_rdata | output | 16 | Registered status word |

## Verification
The hardest case to reach is a set pulse that lands in the same cycle as the clear it races against. Examples are a CPU message write that coincides with a host read, and a mailbox put that coincides with a CPU mailbox read. A lost event would show up only on a later read. The bench drives both pulses in one cycle. It expects the racing read to return the old value and the following read to show the flag still set. It reaches the synchronizer latency by issuing a read in the same cycle the asynchronous level changes.

// File: rtl/hps_pkg.sv
package hps_pkg;

    localparam int unsigned WORD_W  = 16;
    localparam int unsigned NUM_ENG = 2;

    // Bit positions decoded by host software
    localparam int unsigned B_VBUS   = 15;
    localparam int unsigned B_ID     = 14;
    localparam int unsigned B_SOF2   = 12;
    localparam int unsigned B_SOF1   = 10;
    localparam int unsigned B_RST2   = 9;
    localparam int unsigned B_MBX_IN = 8;
    localparam int unsigned B_RES2   = 7;
    localparam int unsigned B_RES1   = 6;
    localparam int unsigned B_MSG2   = 5;
    localparam int unsigned B_MSG1   = 4;
    localparam int unsigned B_DONE2  = 3;
    localparam int unsigned B_DONE1  = 2;
    localparam int unsigned B_RST1   = 1;
    localparam int unsigned B_MBX_OUT = 0;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    typedef struct packed {
        logic vbus;
        logic id;
    } otg_lvl_t;

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] sr_d, sr_q;

    always_comb begin
        sr_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            sr_d[i] = sr_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign sync_out = sr_q[STAGES-1];
endmodule

// File: rtl/hps_flag_cell.sv
module hps_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;   // set has priority
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R7: a set pulse always leaves the flag high
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    // R4/R5/R6: a clear with no set drops the flag
    a_r4_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R5/R6: with neither event the flag keeps its value
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/hps_status_word.sv
module hps_status_word
    import hps_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              vbus_hi_async,
    input  logic              id_async,
    input  logic              mbx_in_put,
    input  logic              cpu_mbx_rd,
    input  logic              cpu_mbx_put,
    input  logic              host_mbx_take,
    input  logic [1:0]        cpu_msg_wr,
    input  logic [1:0]        eng_sof_irq,
    input  logic [1:0]        eng_rst_irq,
    input  logic [1:0]        eng_resume_irq,
    input  logic [1:0]        eng_pkt_done,
    input  logic [1:0]        eng_ep_irq,
    input  logic [1:0]        eng_dev_mode,
    output logic [WORD_W-1:0] stat_rdata
);
    localparam int unsigned OTG_W = $bits(otg_lvl_t);

    otg_lvl_t           otg_s;
    logic [OTG_W-1:0]   otg_raw;
    logic               mbx_in_q;
    logic               mbx_out_q;
    logic [NUM_ENG-1:0] msg_q;
    logic [NUM_ENG-1:0] done_sel;
    rd_state_t          st_d, st_q;
    logic [WORD_W-1:0]  word;

    hps_sync #(.STAGES(SYNC_STAGES), .WIDTH(OTG_W)) u_otg_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({vbus_hi_async, id_async}),
        .sync_out (otg_raw)
    );
    assign otg_s = otg_lvl_t'(otg_raw);

    hps_flag_cell u_mbx_in (
        .clk(clk), .rst_n(rst_n),
        .set_i(mbx_in_put), .clr_i(cpu_mbx_rd), .flag_o(mbx_in_q)
    );

    hps_flag_cell u_mbx_out (
        .clk(clk), .rst_n(rst_n),
        .set_i(cpu_mbx_put), .clr_i(host_mbx_take), .flag_o(mbx_out_q)
    );

    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        hps_flag_cell u_msg (
            .clk(clk), .rst_n(rst_n),
            .set_i(cpu_msg_wr[e]), .clr_i(host_rd), .flag_o(msg_q[e])
        );
        assign done_sel[e] = eng_dev_mode[e] ? eng_ep_irq[e] : eng_pkt_done[e];
    end

    always_comb begin
        word              = '0;
        word[B_VBUS]      = otg_s.vbus;
        word[B_ID]        = otg_s.id;
        word[B_SOF2]      = eng_sof_irq[1];
        word[B_SOF1]      = eng_sof_irq[0];
        word[B_RST2]      = eng_rst_irq[1];
        word[B_RST1]      = eng_rst_irq[0];
        word[B_RES2]      = eng_resume_irq[1];
        word[B_RES1]      = eng_resume_irq[0];
        word[B_MSG2]      = msg_q[1];
        word[B_MSG1]      = msg_q[0];
        word[B_DONE2]     = done_sel[1];
        word[B_DONE1]     = done_sel[0];
        word[B_MBX_IN]    = mbx_in_q;
        word[B_MBX_OUT]   = mbx_out_q;

        st_d = st_q;
        if (host_rd) st_d.rdata = word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_rdata = st_q.rdata;

    // R2: no read strobe, no change of the read data
    a_r2_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(stat_rdata));
    // R10: the reported VBUS level is the synchronizer output at the read edge
    a_r10_vbus_live: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> stat_rdata[B_VBUS] == $past(otg_s.vbus));
    // R5: a host read never clears the incoming-mailbox flag
    a_r5_host_read_keeps_mbx: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !cpu_mbx_rd && mbx_in_q) |=> mbx_in_q);
    // R1: reserved positions stay zero after any read
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> (stat_rdata[13] == 1'b0 && stat_rdata[11] == 1'b0));
endmodule

// File: tb/test_hps_status_word.sv
module test_hps_status_word;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC = 11;
    // {sof[27:26], rst[25:24], res[23:22], done[21:20], ep[19:18], mode[17:16], expected[15:0]}
    localparam logic [27:0] VEC [N_VEC] = '{
        {2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h0000},
        {2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1400},
        {2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h0202},
        {2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 16'h00C0},
        {2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h000C},
        {2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 16'h0000},
        {2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 16'h000C},
        {2'b00, 2'b00, 2'b00, 2'b10, 2'b01, 2'b01, 16'h000C},
        {2'b00, 2'b00, 2'b00, 2'b01, 2'b10, 2'b01, 16'h0000},
        {2'b01, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 16'h0640},
        {2'b10, 2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 16'h1082}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0;
    logic        vbus_hi_async = 1'b0;
    logic        id_async = 1'b0;
    logic        mbx_in_put = 1'b0;
    logic        cpu_mbx_rd = 1'b0;
    logic        cpu_mbx_put = 1'b0;
    logic        host_mbx_take = 1'b0;
    logic [1:0]  cpu_msg_wr = '0;
    logic [1:0]  eng_sof_irq = '0;
    logic [1:0]  eng_rst_irq = '0;
    logic [1:0]  eng_resume_irq = '0;
    logic [1:0]  eng_pkt_done = '0;
    logic [1:0]  eng_ep_irq = '0;
    logic [1:0]  eng_dev_mode = '0;
    logic [15:0] stat_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hps_status_word i_hps_status_word (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd),
        .vbus_hi_async(vbus_hi_async), .id_async(id_async),
        .mbx_in_put(mbx_in_put), .cpu_mbx_rd(cpu_mbx_rd),
        .cpu_mbx_put(cpu_mbx_put), .host_mbx_take(host_mbx_take),
        .cpu_msg_wr(cpu_msg_wr), .eng_sof_irq(eng_sof_irq),
        .eng_rst_irq(eng_rst_irq), .eng_resume_irq(eng_resume_irq),
        .eng_pkt_done(eng_pkt_done), .eng_ep_irq(eng_ep_irq),
        .eng_dev_mode(eng_dev_mode), .stat_rdata(stat_rdata)
    );

    task automatic check(input string req, input logic [15:0] exp);
        checks++;
        if (stat_rdata !== exp) begin
            failures++;
            $display("FAIL %s: stat_rdata=%h expected=%h", req, stat_rdata, exp);
        end
    endtask

    // Read strobe for one edge; returns at the following falling edge
    task automatic do_read();
        @(negedge clk) host_rd = 1'b1;
        @(negedge clk) host_rd = 1'b0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic pulse_msg(input logic [1:0] v);
        @(negedge clk) cpu_msg_wr = v;
        @(negedge clk) cpu_msg_wr = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R3 reset value", 16'h0000);
        rst_n = 1'b1;
        do_read();
        check("R3 latched flags after reset", 16'h0000);

        // R1 R8 R9: vector table of engine levels
        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk);
            {eng_sof_irq, eng_rst_irq, eng_resume_irq,
             eng_pkt_done, eng_ep_irq, eng_dev_mode} = VEC[i][27:16];
            do_read();
            check($sformatf("R8/R9 layout vector %0d", i), VEC[i][15:0]);
        end
        @(negedge clk);
        {eng_sof_irq, eng_rst_irq, eng_resume_irq, eng_pkt_done, eng_ep_irq, eng_dev_mode} = '0;

        // R2: levels change without a read; data holds
        do_read();
        check("R2 clean read", 16'h0000);
        @(negedge clk) eng_sof_irq = 2'b11;
        repeat (3) @(negedge clk);
        check("R2 hold without strobe", 16'h0000);
        eng_sof_irq = 2'b00;

        // R4: message flags set by CPU write, cleared by host read
        pulse_msg(2'b01);
        do_read();
        check("R4 msg1 set", 16'h0010);
        do_read();
        check("R4 msg1 cleared by read", 16'h0000);
        pulse_msg(2'b10);
        do_read();
        check("R4 msg2 set", 16'h0020);
        do_read();
        check("R4 msg2 cleared by read", 16'h0000);

        // R5: incoming mailbox flag survives host reads
        pulse(mbx_in_put);
        do_read();
        check("R5 mailbox in set", 16'h0100);
        do_read();
        check("R5 mailbox in kept after host read", 16'h0100);
        pulse(cpu_mbx_rd);
        do_read();
        check("R5 mailbox in cleared by CPU read", 16'h0000);

        // R6: outgoing mailbox flag
        pulse(cpu_mbx_put);
        do_read();
        check("R6 mailbox out set", 16'h0001);
        do_read();
        check("R6 mailbox out kept after host read", 16'h0001);
        pulse(host_mbx_take);
        do_read();
        check("R6 mailbox out cleared by take", 16'h0000);

        // R7: set races host read on msg1
        @(negedge clk) begin cpu_msg_wr = 2'b01; host_rd = 1'b1; end
        @(negedge clk) begin cpu_msg_wr = 2'b00; host_rd = 1'b0; end
        check("R7 racing read sees old value", 16'h0000);
        do_read();
        check("R7 msg1 survives racing clear", 16'h0010);
        do_read();
        check("R7 msg1 cleared afterwards", 16'h0000);

        // R7: mailbox put races CPU mailbox read
        pulse(mbx_in_put);
        @(negedge clk) begin mbx_in_put = 1'b1; cpu_mbx_rd = 1'b1; end
        @(negedge clk) begin mbx_in_put = 1'b0; cpu_mbx_rd = 1'b0; end
        do_read();
        check("R7 mailbox in survives racing clear", 16'h0100);
        pulse(cpu_mbx_rd);
        do_read();
        check("R7 mailbox in cleared alone", 16'h0000);

        // R10: synchronizer latency on VBUS / ID
        @(negedge clk) begin vbus_hi_async = 1'b1; host_rd = 1'b1; end
        @(negedge clk) host_rd = 1'b0;
        check("R10 vbus not yet through synchronizer", 16'h0000);
        repeat (2) @(negedge clk);
        do_read();
        check("R10 vbus visible", 16'h8000);
        @(negedge clk) id_async = 1'b1;
        repeat (3) @(negedge clk);
        do_read();
        check("R10 vbus and id visible", 16'hC000);
        @(negedge clk) begin vbus_hi_async = 1'b0; id_async = 1'b0; end
        repeat (3) @(negedge clk);
        do_read();
        check("R10 live levels drop", 16'h0000);

        // R3: reset mid-run clears latched flags
        pulse(mbx_in_put);
        pulse_msg(2'b11);
        do_read();
        check("R3 flags before reset", 16'h0130);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        check("R3 read data reset", 16'h0000);
        do_read();
        check("R3 flags cleared by reset", 16'h0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule